// File: doc/BRIEF.md
# ADC Result Compare and Read Interlock

This block is the digital side of a successive-approximation converter. It decides when a conversion starts, tracks whether one is in flight, and takes each finished sample into a result register. The start can come from a software write to the command register or from the rising edge of a hardware trigger pin. The sample is cut to 8, 10 or 12 bits. The converter itself is outside the block: it sees a one-cycle `conv_start` pulse and answers later with a one-cycle `conv_done` pulse that carries right-justified data.

Software can turn on an automatic compare against a programmed threshold. With the compare on, the result register is written only when the compare condition holds. The value written is then the sample minus the threshold, not the raw sample.

Software reads the result as two bytes through a small byte-wide register port. In 10-bit and 12-bit modes, reading the high byte freezes the result register until the low byte is read. This keeps the two halves coherent, and any conversion that lands in between is dropped.

Top module: `adc_result_ctrl`

Register map (`reg_addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | command | bits 1:0 select resolution (0 = 8-bit, 1 = 10-bit, 2 or 3 = 12-bit); a write here starts and aborts conversions as described below |
| 1 | status/control | bit 7 active, bit 6 trigger select, bit 5 compare enable, bit 4 compare direction |
| 2 | result high | result bits 11:8 in bits 3:0 |
| 3 | result low | result bits 7:0 |
| 4 | compare high | compare value bits 11:8 in bits 3:0 |
| 5 | compare low | compare value bits 7:0 |

## Requirements
- R1: The stored result is the low 8, 10 or 12 bits of `conv_data`, as set by the command register resolution field. The result-high register returns result bits 11:8 in its bits 3:0, and result-low returns bits 7:0. In 10-bit mode bits 11:10 read 0, and in 8-bit mode bits 11:8 read 0.
- R2: With compare enable (status/control bit 5) at 0, every accepted completion loads the result register.
- R3: With compare enable at 1, an accepted completion loads the result register only if the compare condition holds. Otherwise the register keeps its value.
- R4: On a compare hit, the stored value is (sample − compare value) modulo 2^width, where width is the active resolution.
- R5: Compare direction (status/control bit 4) at 0 hits when sample < compare value. At 1 it hits when sample ≥ compare value. Both operands are cut to the active width.
- R6: In 10-bit and 12-bit modes, a read of result-high blocks every later load until result-low is read. A completion that arrives while blocked is discarded.
- R7: In 8-bit mode, reading result-high does not block later loads.
- R8: The active flag (status/control bit 7) sets when a conversion starts. It clears when that conversion completes or is aborted. A `conv_done` that arrives while the flag is clear is ignored.
- R9: With trigger select (status/control bit 6) at 0, a write to the command register starts a conversion. With it at 1, a rising edge on `hw_trig` starts one and command writes do not. Each start gives one `conv_start` pulse.
- R10: A hardware trigger edge that arrives while a conversion is active is ignored.
- R11: A command-register write during an active conversion aborts it. The active flag clears, unless software trigger mode restarts the conversion in the same cycle.
- R12: All status/control bits reset to 0. Bit 7 is read-only, and bits 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; drives the read interlock |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| hw_trig | input | 1 | Hardware trigger level; its rising edge is used |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_data | input | 12 | Right-justified sample, valid with `conv_done` |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are single-cycle strobes. They also assume that `conv_done` is a one-cycle pulse and that the resolution field does not change between a high-byte read and the matching low-byte read. The bench drives every strobe for exactly one clock. It changes the resolution only after a full high-then-low read pair. It pulses `conv_done` only once the active flag has been set or cleared on purpose, and the completion-while-idle and completion-after-abort cases are stimulated on purpose.

// File: rtl/adc_rc_pkg.sv
// Package: shared widths, register addresses, resolution encoding and the
// width mask used by the compare and result logic.
// Assumes samples are at most 12 bits, so the high result byte fits in one byte.
package adc_rc_pkg;
    localparam int SMP_W  = 12;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        RES_8   = 2'd0,
        RES_10  = 2'd1,
        RES_12  = 2'd2,
        RES_12X = 2'd3
    } res_e;

    localparam logic [ADDR_W-1:0] A_CMD    = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
    localparam logic [ADDR_W-1:0] A_RES_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_RES_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd5;

    // Returns the all-ones mask for the active resolution.
    function automatic logic [SMP_W-1:0] res_mask(input res_e r);
        case (r)
            RES_8:   return {SMP_W{1'b1}} >> (SMP_W - 8);
            RES_10:  return {SMP_W{1'b1}} >> (SMP_W - 10);
            default: return {SMP_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/adc_trig_ctrl.sv
// Trigger and active-flag control. Detects the rising edge of the hardware
// trigger, handles the abort caused by a command write, issues the start pulse
// and qualifies completions.
// Assumes done_in is a one-cycle pulse; completions seen while idle are dropped.
module adc_trig_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_hw_sel,
    input  logic hw_trig,
    input  logic cmd_wr,
    input  logic done_in,
    output logic active_o,
    output logic start_o,
    output logic done_acc_o
);
    logic hw_prev_q;
    logic active_q;
    logic rise;
    logic act_eff;

    // Works out the abort, start and accept decisions for this cycle.
    always_comb begin
        rise       = hw_trig & ~hw_prev_q;
        act_eff    = active_q & ~cmd_wr;
        done_acc_o = done_in & act_eff;
        start_o    = ~act_eff & (trig_hw_sel ? rise : cmd_wr);
    end

    // Holds the trigger history and the active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_prev_q <= 1'b0;
            active_q  <= 1'b0;
        end else begin
            hw_prev_q <= hw_trig;
            if (start_o)         active_q <= 1'b1;
            else if (done_acc_o) active_q <= 1'b0;
            else                 active_q <= act_eff;
        end
    end

    assign active_o = active_q;

    // R8
    start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> active_q);
    // R8
    done_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_acc_o |=> !active_q);
    // R10
    busy_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !cmd_wr && hw_trig && !hw_prev_q) |-> !start_o);
    // R11
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && cmd_wr && trig_hw_sel && !(hw_trig && !hw_prev_q)) |=> !active_q);
endmodule

// File: rtl/adc_cmp_unit.sv
// Compare unit. Cuts the sample and the threshold to the active width, checks
// the selected condition and forms the wrapped difference.
// Purely combinational; the caller decides whether the result is used.
module adc_cmp_unit
    import adc_rc_pkg::*;
(
    input  res_e             res,
    input  logic [SMP_W-1:0] sample,
    input  logic [SMP_W-1:0] cmp_val,
    input  logic             gt_sel,
    output logic [SMP_W-1:0] samp_m,
    output logic             hit,
    output logic [SMP_W-1:0] diff
);
    logic [SMP_W-1:0] mask;
    logic [SMP_W-1:0] cmp_m;

    // Masks the operands, then evaluates the condition and the difference.
    always_comb begin
        mask   = res_mask(res);
        samp_m = sample & mask;
        cmp_m  = cmp_val & mask;
        hit    = gt_sel ? (samp_m >= cmp_m) : (samp_m < cmp_m);
        diff   = (samp_m - cmp_m) & mask;
    end
endmodule

// File: rtl/adc_result_store.sv
// Result register with the high-then-low read interlock. Loads the raw masked
// sample, or the compare difference on a hit, unless the interlock blocks it.
// Assumes the read strobes last one cycle and the resolution is held steady
// while a byte pair is being read.
module adc_result_store
    import adc_rc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_acc,
    input  logic             cmp_en,
    input  logic             hit,
    input  logic [SMP_W-1:0] diff,
    input  logic [SMP_W-1:0] samp_m,
    input  res_e             res,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [SMP_W-1:0] result_o
);
    logic [SMP_W-1:0] result_q;
    logic             locked_q;
    logic             narrow;
    logic             blocked;
    logic             upd;

    // Decides whether this cycle's completion is allowed to load.
    always_comb begin
        narrow  = (res == RES_8);
        blocked = ~narrow & ((locked_q & ~rd_lo) | rd_hi);
        upd     = done_acc & (~cmp_en | hit) & ~blocked;
    end

    // Holds the result value and the interlock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            locked_q <= 1'b0;
        end else begin
            if (upd) result_q <= cmp_en ? diff : samp_m;
            if (rd_lo)                locked_q <= 1'b0;
            else if (rd_hi && !narrow) locked_q <= 1'b1;
        end
    end

    assign result_o = result_q;

    // R6
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !rd_lo && res != RES_8) |=> $stable(result_q));
    // R6
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !rd_lo && res != RES_8) |=> locked_q);
    // R1
    narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && res == RES_8) |=> (result_q[SMP_W-1:8] == '0));
    // R3
    miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && cmp_en && !hit) |=> $stable(result_q));
endmodule

// File: rtl/adc_result_ctrl.sv
// Top level: holds the configuration registers, decodes the byte-wide register
// port and wires together trigger control, compare and result storage.
// Assumes single-cycle read and write strobes, and a reg_rdata that may be
// sampled in the same cycle as reg_rd.
module adc_result_ctrl
    import adc_rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              hw_trig,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [SMP_W-1:0]  conv_data
);
    localparam int HI_W = SMP_W - 8;

    res_e             res_q;
    logic             trig_sel_q;
    logic             cmp_en_q;
    logic             cmp_gt_q;
    logic [SMP_W-1:0] cmp_val_q;
    logic             active;
    logic             done_acc;
    logic             cmd_wr;
    logic             rd_hi;
    logic             rd_lo;
    logic [SMP_W-1:0] samp_m;
    logic             hit;
    logic [SMP_W-1:0] diff;
    logic [SMP_W-1:0] result;

    // Decodes the strobes for the command write and the result byte reads.
    always_comb begin
        cmd_wr = reg_wr && (reg_addr == A_CMD);
        rd_hi  = reg_rd && (reg_addr == A_RES_HI);
        rd_lo  = reg_rd && (reg_addr == A_RES_LO);
    end

    // Holds the configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= RES_8;
            trig_sel_q <= 1'b0;
            cmp_en_q   <= 1'b0;
            cmp_gt_q   <= 1'b0;
            cmp_val_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CMD:    res_q <= res_e'(reg_wdata[1:0]);
                A_STAT: begin
                    trig_sel_q <= reg_wdata[6];
                    cmp_en_q   <= reg_wdata[5];
                    cmp_gt_q   <= reg_wdata[4];
                end
                A_CMP_HI: cmp_val_q[SMP_W-1:8] <= reg_wdata[HI_W-1:0];
                A_CMP_LO: cmp_val_q[7:0]       <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // Read multiplexer for the byte-wide register port.
    always_comb begin
        case (reg_addr)
            A_CMD:    reg_rdata = {6'b0, res_q};
            A_STAT:   reg_rdata = {active, trig_sel_q, cmp_en_q, cmp_gt_q, 4'b0};
            A_RES_HI: reg_rdata = {{(16-SMP_W){1'b0}}, result[SMP_W-1:8]};
            A_RES_LO: reg_rdata = result[7:0];
            A_CMP_HI: reg_rdata = {{(16-SMP_W){1'b0}}, cmp_val_q[SMP_W-1:8]};
            A_CMP_LO: reg_rdata = cmp_val_q[7:0];
            default:  reg_rdata = 8'h00;
        endcase
    end

    adc_trig_ctrl u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_hw_sel (trig_sel_q),
        .hw_trig     (hw_trig),
        .cmd_wr      (cmd_wr),
        .done_in     (conv_done),
        .active_o    (active),
        .start_o     (conv_start),
        .done_acc_o  (done_acc)
    );

    adc_cmp_unit u_cmp (
        .res     (res_q),
        .sample  (conv_data),
        .cmp_val (cmp_val_q),
        .gt_sel  (cmp_gt_q),
        .samp_m  (samp_m),
        .hit     (hit),
        .diff    (diff)
    );

    adc_result_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_acc (done_acc),
        .cmp_en   (cmp_en_q),
        .hit      (hit),
        .diff     (diff),
        .samp_m   (samp_m),
        .res      (res_q),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo),
        .result_o (result)
    );

    // R12
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STAT) |-> (reg_rdata[3:0] == 4'b0));
endmodule

// File: tb/adc_result_ctrl_test.sv
// Self-checking bench: a table of compare and resolution vectors walked by one
// loop, followed by directed tests for reset, triggering, abort and interlock.
module adc_result_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        hw_trig = 1'b0;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = 12'h000;

    int checks = 0;
    int fails = 0;
    int start_cnt = 0;
    bit finished = 1'b0;

    adc_result_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_trig(hw_trig), .conv_start(conv_start),
        .conv_done(conv_done), .conv_data(conv_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n && conv_start) start_cnt <= start_cnt + 1;

    // Vector fields: res[39:38] cmp_en[37] gt[36] cmp[35:24] sample[23:12] expected[11:0]
    localparam logic [39:0] VEC [11] = '{
        {2'd2, 1'b0, 1'b0, 12'h000, 12'hABC, 12'hABC},
        {2'd1, 1'b0, 1'b0, 12'h000, 12'hFFF, 12'h3FF},
        {2'd0, 1'b0, 1'b0, 12'h000, 12'h5A7, 12'h0A7},
        {2'd2, 1'b1, 1'b1, 12'h100, 12'h345, 12'h245},
        {2'd2, 1'b1, 1'b1, 12'h800, 12'h7FF, 12'h245},
        {2'd2, 1'b1, 1'b0, 12'h800, 12'h7FF, 12'hFFF},
        {2'd2, 1'b1, 1'b0, 12'h123, 12'h123, 12'hFFF},
        {2'd2, 1'b1, 1'b1, 12'h123, 12'h123, 12'h000},
        {2'd1, 1'b1, 1'b0, 12'h200, 12'h010, 12'h210},
        {2'd0, 1'b1, 1'b1, 12'h040, 12'h3C0, 12'h080},
        {2'd0, 1'b1, 1'b1, 12'h0F0, 12'h0C0, 12'h080}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic done(input logic [11:0] s);
        @(negedge clk);
        conv_data = s; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic chk_result(input string req, input logic [11:0] exp);
        logic [7:0] d;
        rd(3'd2, d); chk(req, d, {4'h0, exp[11:8]});
        rd(3'd3, d); chk(req, d, exp[7:0]);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] d;
        int sc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 R1: reset state
        rd(3'd1, d); chk("R12 reset status", d, 8'h00);
        rd(3'd0, d); chk("R1 reset resolution", d, 8'h00);
        chk_result("R1 reset result", 12'h000);

        // Vector loop: R1 R2 R3 R4 R5
        for (int i = 0; i < 11; i++) begin
            wr(3'd1, {2'b00, VEC[i][37], VEC[i][36], 4'h0});
            wr(3'd4, {4'h0, VEC[i][35:32]});
            wr(3'd5, VEC[i][31:24]);
            wr(3'd0, {6'b0, VEC[i][39:38]});
            done(VEC[i][23:12]);
            chk_result($sformatf("R1 R2 R3 R4 R5 vector %0d", i), VEC[i][11:0]);
        end

        // R12: reserved and read-only bits
        wr(3'd1, 8'hFF);
        rd(3'd1, d); chk("R12 reserved bits", d, 8'h70);
        wr(3'd1, 8'h00);

        // R8 R9: software start and completion
        sc = start_cnt;
        wr(3'd0, 8'h02);
        rd(3'd1, d); chk("R8 active after soft start", d, 8'h80);
        chk("R9 one start pulse", 8'(start_cnt - sc), 8'd1);
        done(12'h456);
        rd(3'd1, d); chk("R8 active cleared on done", d, 8'h00);
        chk_result("R2 soft conversion", 12'h456);

        // R8: completion while idle is ignored
        done(12'h111);
        chk_result("R8 idle done ignored", 12'h456);

        // R9 R10: hardware trigger
        wr(3'd1, 8'h40);
        sc = start_cnt;
        wr(3'd0, 8'h02);
        rd(3'd1, d); chk("R9 command write no start in hw mode", d, 8'h40);
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk);
        rd(3'd1, d); chk("R9 hw edge starts", d, 8'hC0);
        @(negedge clk); hw_trig = 1'b0;
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); hw_trig = 1'b0;
        @(negedge clk);
        chk("R10 busy edge ignored", 8'(start_cnt - sc), 8'd1);
        done(12'h789);
        chk_result("R9 hw conversion result", 12'h789);

        // R11: abort by command write
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); hw_trig = 1'b0;
        rd(3'd1, d); chk("R11 active before abort", d, 8'hC0);
        wr(3'd0, 8'h02);
        rd(3'd1, d); chk("R11 active cleared by abort", d, 8'h40);
        done(12'h222);
        chk_result("R11 aborted done dropped", 12'h789);

        // R6: interlock in 12-bit mode
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h02);
        done(12'hA5A);
        rd(3'd2, d); chk("R6 high byte", d, 8'h0A);
        wr(3'd0, 8'h02);
        done(12'h3C3);
        rd(3'd3, d); chk("R6 low byte coherent", d, 8'h5A);
        chk_result("R6 blocked result discarded", 12'hA5A);
        wr(3'd0, 8'h02);
        done(12'h3C3);
        chk_result("R6 loads after release", 12'h3C3);

        // R7: no interlock in 8-bit mode
        wr(3'd0, 8'h00);
        done(12'h012);
        rd(3'd2, d); chk("R7 high byte 8-bit", d, 8'h00);
        wr(3'd0, 8'h00);
        done(12'h034);
        rd(3'd3, d); chk("R7 load after high read", d, 8'h34);

        summary();
    end
endmodule